// File: doc/BRIEF.md
# Program Counter and Next-Address Unit

This block holds the instruction fetch address of a simple single-issue processor and chooses the value it takes at the next clock edge. Three kinds of next address are possible. The first is the sequential word after the current one. The second is a PC-relative target for a conditional branch whose compare came out equal. The third is a pseudo-direct jump target, which keeps the top region bits of the incremented address and fills the rest from the instruction's 26-bit target field.

Instruction decode drives two request lines into the unit, one for a branch and one for a jump. The ALU compare drives an equality flag. The decoder also supplies the raw 16-bit offset and the 26-bit jump field. The unit exports the current fetch address and the sequential address. The register has no enable, so it loads a new value on every rising clock edge.

Top module: `pc_next_unit`

## Requirements
- R1: A high `rst` at a rising edge loads `fetchAddr` with 0. This is synchronous and active high, and it overrides every request input.
- R2: `seqAddr` always equals `fetchAddr + 4` modulo 2^32. `fetchAddr` bits [1:0] stay 0 at all times.
- R3: With `brReq` = 0 and `jmpReq` = 0, the next `fetchAddr` is the current `seqAddr`.
- R4: With `brReq` = 1, `cmpEq` = 1 and `jmpReq` = 0, the next `fetchAddr` is `seqAddr` plus `offsetImm` sign-extended from bit 15 and shifted left by two. Offset 0xFFFF means -4 bytes and 0x8000 means -131072 bytes.
- R5: With `brReq` = 1, `cmpEq` = 0 and `jmpReq` = 0, the next `fetchAddr` is `seqAddr`.
- R6: With `jmpReq` = 1, the next `fetchAddr` is {`seqAddr`[31:28], `jmpField`, 2'b00}. The region bits come from the incremented address, not from the current one.
- R7: When `jmpReq` and a taken branch occur together, the jump target wins.
- R8: Every addition wraps modulo 2^32 and raises no indication. Stepping past 0xFFFFFFFC gives 0, and a backward branch below 0 wraps to the top of the space.
- R9: `cmpEq` and `offsetImm` have no effect while `brReq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| brReq | input | 1 | Conditional branch requested |
| cmpEq | input | 1 | Equality result of the operand compare |
| jmpReq | input | 1 | Jump requested |
| offsetImm | input | 16 | Signed word offset of a branch |
| jmpField | input | 26 | Word target field of a jump |
| fetchAddr | output | 32 | Current program counter, the fetch address |
| seqAddr | output | 32 | Current program counter plus 4 |

## Verification
The hardest cases to reach are the ones that wrap the address space. A jump only ever keeps the current region bits, so the register cannot be steered to the top of memory by a jump alone. The stimulus instead takes a taken branch with the most negative offset from a low address, which drops the counter into region 0xF. A jump issued from there lands on 0xFFFFFFFC. One plain step then checks that the sequential adder wraps to zero. The jump-over-branch priority case and the case where `cmpEq` is high without a branch request sit in the same table.

// File: rtl/pc_next_pkg.sv
package pc_next_pkg;

  // Strobes passed from next-address control to the datapath
  typedef struct packed {
    logic takeJump;    // select the pseudo-direct jump target
    logic takeBranch;  // select the PC-relative branch target
  } nextSel_t;

endpackage

// File: rtl/pc_next_ctrl.sv
module pc_next_ctrl
  import pc_next_pkg::*;
(
  input  logic     brReq,
  input  logic     cmpEq,
  input  logic     jmpReq,
  output nextSel_t sel
);

  logic branchTaken;

  always_comb begin
    branchTaken    = brReq & cmpEq;
    sel.takeJump   = jmpReq;
    // jump has priority: a taken branch is masked while a jump is requested
    sel.takeBranch = branchTaken & ~jmpReq;
  end

endmodule

// File: rtl/pc_next_dp.sv
module pc_next_dp
  import pc_next_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IMM_W      = 16,
  parameter int TGT_W      = 26,
  parameter int WORD_SHIFT = 2,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  nextSel_t          sel,
  input  logic [IMM_W-1:0]  offsetImm,
  input  logic [TGT_W-1:0]  jmpField,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [ADDR_W-1:0] seqAddr
);

  localparam int REGION_W = ADDR_W - TGT_W - WORD_SHIFT;
  localparam int EXT_W    = ADDR_W - IMM_W - WORD_SHIFT;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << WORD_SHIFT;

  logic [ADDR_W-1:0] pcQ;
  logic [ADDR_W-1:0] pcIncr;
  logic [ADDR_W-1:0] brOffset;
  logic [ADDR_W-1:0] brTarget;
  logic [ADDR_W-1:0] jmpTarget;
  logic [ADDR_W-1:0] afterBranch;
  logic [ADDR_W-1:0] pcNext;

  // dedicated sequential incrementer
  assign pcIncr = pcQ + STEP;

  // sign-extended, word-scaled branch displacement
  assign brOffset = {{EXT_W{offsetImm[IMM_W-1]}}, offsetImm, {WORD_SHIFT{1'b0}}};

  // branch target adder works from the incremented address
  assign brTarget = pcIncr + brOffset;

  // pseudo-direct jump: region bits of the incremented address
  generate
    if (REGION_W > 0) begin : g_region
      assign jmpTarget = {pcIncr[ADDR_W-1 -: REGION_W], jmpField, {WORD_SHIFT{1'b0}}};
    end else begin : g_flat
      assign jmpTarget = ADDR_W'({jmpField, {WORD_SHIFT{1'b0}}});
    end
  endgenerate

  // two cascaded selectors: branch first, then jump
  always_comb begin
    afterBranch = sel.takeBranch ? brTarget : pcIncr;
    pcNext      = sel.takeJump ? jmpTarget : afterBranch;
  end

  always_ff @(posedge clk) begin
    if (rst) pcQ <= RESET_ADDR;
    else     pcQ <= pcNext;
  end

  assign fetchAddr = pcQ;
  assign seqAddr   = pcIncr;

endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
  import pc_next_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int TGT_W  = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              brReq,
  input  logic              cmpEq,
  input  logic              jmpReq,
  input  logic [IMM_W-1:0]  offsetImm,
  input  logic [TGT_W-1:0]  jmpField,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [ADDR_W-1:0] seqAddr
);

  nextSel_t sel;

  pc_next_ctrl ctrl_i (
    .brReq (brReq),
    .cmpEq (cmpEq),
    .jmpReq(jmpReq),
    .sel   (sel)
  );

  pc_next_dp #(
    .ADDR_W    (ADDR_W),
    .IMM_W     (IMM_W),
    .TGT_W     (TGT_W),
    .WORD_SHIFT(2),
    .RESET_ADDR('0)
  ) dp_i (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .offsetImm(offsetImm),
    .jmpField (jmpField),
    .fetchAddr(fetchAddr),
    .seqAddr  (seqAddr)
  );

endmodule

// File: rtl/pc_next_unit_chk.sv
module pc_next_unit_chk #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int TGT_W  = 26
) (
  input logic              clk,
  input logic              rst,
  input logic              brReq,
  input logic              cmpEq,
  input logic              jmpReq,
  input logic [IMM_W-1:0]  offsetImm,
  input logic [TGT_W-1:0]  jmpField,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic [ADDR_W-1:0] seqAddr
);

  localparam int EXT_W    = ADDR_W - IMM_W - 2;
  localparam int REGION_W = ADDR_W - TGT_W - 2;

  // R1: reset loads zero whatever the requests are
  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> fetchAddr == '0);

  // R2: fetch address stays word aligned
  a_r2_aligned: assert property (@(posedge clk) disable iff (rst)
    fetchAddr[1:0] == 2'b00);

  // R3: no request, step to the next word
  a_r3_sequential: assert property (@(posedge clk) disable iff (rst)
    (!brReq && !jmpReq) |=> fetchAddr == $past(fetchAddr) + ADDR_W'(4));

  // R4: taken branch
  a_r4_branch_taken: assert property (@(posedge clk) disable iff (rst)
    (brReq && cmpEq && !jmpReq) |=>
      fetchAddr == $past(seqAddr) +
        {{EXT_W{$past(offsetImm[IMM_W-1])}}, $past(offsetImm), 2'b00});

  // R5: untaken branch
  a_r5_branch_not_taken: assert property (@(posedge clk) disable iff (rst)
    (brReq && !cmpEq && !jmpReq) |=> fetchAddr == $past(seqAddr));

  // R6 and R7: jump target, taking priority over any branch
  a_r6_jump_target: assert property (@(posedge clk) disable iff (rst)
    jmpReq |=> fetchAddr ==
      {$past(seqAddr[ADDR_W-1 -: REGION_W]), $past(jmpField), 2'b00});

endmodule

bind pc_next_unit pc_next_unit_chk #(
  .ADDR_W(ADDR_W),
  .IMM_W (IMM_W),
  .TGT_W (TGT_W)
) chk_i (.*);

// File: tb/pc_next_unit_tb_top.sv
`timescale 1ns/1ps
module pc_next_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        brReq = 1'b0;
  logic        cmpEq = 1'b0;
  logic        jmpReq = 1'b0;
  logic [15:0] offsetImm = '0;
  logic [25:0] jmpField = '0;
  logic [31:0] fetchAddr;
  logic [31:0] seqAddr;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  pc_next_unit dut_i (
    .clk(clk), .rst(rst), .brReq(brReq), .cmpEq(cmpEq), .jmpReq(jmpReq),
    .offsetImm(offsetImm), .jmpField(jmpField),
    .fetchAddr(fetchAddr), .seqAddr(seqAddr)
  );

  typedef struct packed {
    logic        br;
    logic        eq;
    logic        jmp;
    logic [15:0] imm;
    logic [25:0] tgt;
    logic [31:0] expPc;
  } vec_t;

  localparam int NVEC = 12;
  // starting from fetchAddr = 0 after reset
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 1'b0, 16'h0000, 26'h0000000, 32'h0000_0004}, // R3
    '{1'b1, 1'b1, 1'b0, 16'h0003, 26'h0000000, 32'h0000_0014}, // R4 forward
    '{1'b1, 1'b0, 1'b0, 16'h0003, 26'h0000000, 32'h0000_0018}, // R5
    '{1'b0, 1'b1, 1'b0, 16'h7FFF, 26'h0000000, 32'h0000_001C}, // R9
    '{1'b0, 1'b0, 1'b1, 16'h0000, 26'h0000100, 32'h0000_0400}, // R6
    '{1'b1, 1'b1, 1'b1, 16'h0005, 26'h0000040, 32'h0000_0100}, // R7
    '{1'b1, 1'b1, 1'b0, 16'hFFFF, 26'h0000000, 32'h0000_0100}, // R4 backward
    '{1'b1, 1'b1, 1'b0, 16'h8000, 26'h0000000, 32'hFFFE_0104}, // R8 wrap down
    '{1'b0, 1'b0, 1'b1, 16'h0000, 26'h3FFFFFF, 32'hFFFF_FFFC}, // R6 region F
    '{1'b0, 1'b0, 1'b0, 16'h0000, 26'h0000000, 32'h0000_0000}, // R8 wrap up
    '{1'b1, 1'b1, 1'b0, 16'h7FFF, 26'h0000000, 32'h0002_0000}, // R4 max
    '{1'b0, 1'b0, 1'b1, 16'h0000, 26'h0000000, 32'h0000_0000}  // R6 region 0
  };

  function automatic string tagOf(int i);
    case (i)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R9";
      4: return "R6";
      5: return "R7";
      6: return "R4";
      7: return "R8";
      8: return "R6";
      9: return "R8";
      10: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin : watchdog
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    repeat (2) @(negedge clk);
    check("R1", fetchAddr, 32'h0);
    check("R2", seqAddr, 32'h4);
    rst = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      brReq     = VECS[i].br;
      cmpEq     = VECS[i].eq;
      jmpReq    = VECS[i].jmp;
      offsetImm = VECS[i].imm;
      jmpField  = VECS[i].tgt;
      @(negedge clk);
      check(tagOf(i), fetchAddr, VECS[i].expPc);
      check("R2", seqAddr, VECS[i].expPc + 32'd4);
    end
    // walk away from zero, then reset with requests active
    brReq = 1'b0; cmpEq = 1'b0; jmpReq = 1'b0;
    repeat (3) @(negedge clk);
    check("R3", fetchAddr, 32'h0000_000C);
    rst = 1'b1; jmpReq = 1'b1; brReq = 1'b1; cmpEq = 1'b1; jmpField = 26'h0ABCDEF;
    @(negedge clk);
    check("R1", fetchAddr, 32'h0);
    rst = 1'b0; jmpReq = 1'b0; brReq = 1'b0; cmpEq = 1'b0;
    @(negedge clk);
    check("R3", fetchAddr, 32'h4);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule